// File: doc/BRIEF.md
# Program Counter and Return Stack

This block holds the 13-bit fetch address of a small accumulator-style processor. Each cycle it picks the next address from one of several sources: hold, sequential increment, a write to the low byte, a jump or call with an 11-bit target field, a return, or the interrupt vector. A 5-bit high-address latch, owned by this block and written through its own port, supplies the upper address bits. The slice of the latch that is used depends on the source. A low-byte write takes all five latch bits. A jump or call takes only the top two bits, because the target field already covers the lower eleven.

An 8-entry circular return stack saves full 13-bit return addresses on calls and on interrupt entry, and gives them back on returns. It has no overflow or underflow detection. A ninth push overwrites the oldest entry. A pop with nothing pushed moves the pointer back by one, modulo the depth, and returns whatever that entry holds.

A parameter can shrink the implemented address space to 4K words. Every address the block produces is then folded into the lower 4K, so an address above 0FFFh wraps into the implemented space.

Top module: `pcu_top`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0000h, the high-address latch to 00h, the stack pointer to 0 and every stack entry to 0000h.
- R2: When only `inc_en` is asserted, the PC becomes PC+1 on the next edge, and 1FFFh wraps to 0000h.
- R3: A low-byte write loads PC[7:0] from `lo_data` and PC[12:8] from latch bits 4:0, with no carry into the upper bits. An addition to the low byte is applied the same way.
- R4: A jump loads PC[10:0] from `jmp_tgt` and PC[12:11] from latch bits 4:3.
- R5: A call loads the PC the same way as a jump and pushes PC+1 (the return address) onto the stack.
- R6: A return pops the most recently pushed 13-bit entry into the PC. Push and pop never change the high-address latch.
- R7: An interrupt vector request loads 0004h and pushes the current PC, unincremented.
- R8: The stack holds 8 entries in a circle. The ninth push overwrites the first entry, and the tenth overwrites the second.
- R9: A pop with nothing left on the stack steps the pointer back modulo 8 and returns the stored value at that entry.
- R10: With `IMPL_W`=12, every address is reduced modulo 4096: PC[12] is always 0, 0FFFh increments to 0000h, and jumps or low-byte writes that point above 0FFFh land in the lower 4K.
- R11: When several requests are asserted together, the priority is interrupt vector, then return, then call, then jump, then low-byte write, then increment. Only the winner acts on the PC or the stack.
- R12: `pcl_o` always equals PC[7:0]. PC[12:8] has no separate readable output.
- R13: A latch write updates `latch_o` on the next edge and leaves the PC unchanged. A PC load in the same cycle uses the old latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_en | input | 1 | Sequential increment strobe |
| lo_wr | input | 1 | Low-byte write (or computed jump) |
| lo_data | input | 8 | Data for the low-byte write |
| jmp_req | input | 1 | Jump request |
| call_req | input | 1 | Call request (jump plus push) |
| jmp_tgt | input | 11 | Target field of jump or call |
| ret_req | input | 1 | Return (pop into PC) |
| irq_vec | input | 1 | Interrupt vector entry (push, go to 0004h) |
| hl_wr | input | 1 | High-address latch write enable |
| hl_data | input | 5 | High-address latch write data |
| pc_o | output | 13 | Current program counter |
| pcl_o | output | 8 | Readable low byte of the PC |
| latch_o | output | 5 | Current high-address latch value |

## Verification
Several assertions name a single request and exclude all higher-priority requests in their antecedent, so they hold even when requests overlap. The stack pointer properties assume that a push and a pop never win in the same cycle, which the source selector guarantees by priority. Most stimulus drives one request per cycle. Separate vectors assert several requests together to test the priority order and the same-cycle latch write, and a run of nine calls followed by ten returns walks the pointer around the circle and past empty.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int PC_W   = 13;
    localparam int LO_W   = 8;
    localparam int LAT_W  = PC_W - LO_W;
    localparam int TGT_W  = 11;
    localparam int PG_W   = PC_W - TGT_W;
    localparam logic [PC_W-1:0] VEC_ADDR = 13'h0004;

    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INC  = 3'd1,
        SRC_LOWR = 3'd2,
        SRC_JUMP = 3'd3,
        SRC_CALL = 3'd4,
        SRC_RET  = 3'd5,
        SRC_VEC  = 3'd6
    } pc_src_e;

    typedef struct packed {
        logic inc;
        logic lowr;
        logic jump;
        logic call;
        logic ret;
        logic vec;
    } pc_req_t;

    function automatic logic [PC_W-1:0] impl_mask(input int impl_w);
        return {PC_W{1'b1}} >> (PC_W - impl_w);
    endfunction
endpackage

// File: rtl/pcu_srcsel.sv
module pcu_srcsel
    import pcu_pkg::*;
(
    input  pc_req_t req,
    output pc_src_e src,
    output logic    push,
    output logic    pop
);
    always_comb begin
        if (req.vec)       src = SRC_VEC;
        else if (req.ret)  src = SRC_RET;
        else if (req.call) src = SRC_CALL;
        else if (req.jump) src = SRC_JUMP;
        else if (req.lowr) src = SRC_LOWR;
        else if (req.inc)  src = SRC_INC;
        else               src = SRC_HOLD;
    end

    assign push = (src == SRC_CALL) || (src == SRC_VEC);
    assign pop  = (src == SRC_RET);
endmodule

// File: rtl/pcu_next.sv
module pcu_next
    import pcu_pkg::*;
#(
    parameter int IMPL_W = PC_W
) (
    input  pc_src_e          src,
    input  logic [PC_W-1:0]  pc,
    input  logic [LAT_W-1:0] lat,
    input  logic [LO_W-1:0]  lo_data,
    input  logic [TGT_W-1:0] tgt,
    input  logic [PC_W-1:0]  pop_data,
    output logic [PC_W-1:0]  nxt,
    output logic [PC_W-1:0]  push_data
);
    localparam logic [PC_W-1:0] MASK = impl_mask(IMPL_W);

    logic [PC_W-1:0] seq;
    logic [PC_W-1:0] branch;
    logic [PC_W-1:0] lowr;

    assign seq    = (pc + 1'b1) & MASK;
    assign branch = {lat[LAT_W-1 -: PG_W], tgt} & MASK;
    assign lowr   = {lat, lo_data} & MASK;

    always_comb begin
        unique case (src)
            SRC_INC:  nxt = seq;
            SRC_LOWR: nxt = lowr;
            SRC_JUMP: nxt = branch;
            SRC_CALL: nxt = branch;
            SRC_RET:  nxt = pop_data & MASK;
            SRC_VEC:  nxt = VEC_ADDR & MASK;
            default:  nxt = pc;
        endcase
    end

    assign push_data = (src == SRC_VEC) ? pc : seq;
endmodule

// File: rtl/pcu_retstack.sv
module pcu_retstack
    import pcu_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] pop_data
);
    localparam int SP_W = $clog2(DEPTH);

    logic [PC_W-1:0] mem [DEPTH];
    logic [SP_W-1:0] sp;
    logic [SP_W-1:0] sp_dn;

    assign sp_dn    = sp - 1'b1;
    assign pop_data = mem[sp_dn];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= push_data;
            sp      <= sp + 1'b1;
        end else if (pop) begin
            sp <= sp_dn;
        end
    end

    // R8: pointer advances circularly on push
    p_sp_push_r8: assert property (@(posedge clk) disable iff (rst)
        push |=> sp == $past(sp) + 1'b1);
    // R9: pointer steps back circularly on pop, even when empty
    p_sp_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> sp == $past(sp) - 1'b1);
    // R8: pushed value lands in the slot
    p_push_store_r8: assert property (@(posedge clk) disable iff (rst)
        push |=> mem[$past(sp)] == $past(push_data));
endmodule

// File: rtl/pcu_hilatch.sv
module pcu_hilatch
    import pcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [LAT_W-1:0] din,
    output logic [LAT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= din;
    end

    // R13: latch holds without a write
    p_latch_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(q));
endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int IMPL_W    = 13,
    parameter int STK_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inc_en,
    input  logic        lo_wr,
    input  logic [7:0]  lo_data,
    input  logic        jmp_req,
    input  logic        call_req,
    input  logic [10:0] jmp_tgt,
    input  logic        ret_req,
    input  logic        irq_vec,
    input  logic        hl_wr,
    input  logic [4:0]  hl_data,
    output logic [12:0] pc_o,
    output logic [7:0]  pcl_o,
    output logic [4:0]  latch_o
);
    pc_req_t          req;
    pc_src_e          src;
    logic             push;
    logic             pop;
    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  pc_d;
    logic [PC_W-1:0]  push_data;
    logic [PC_W-1:0]  pop_data;
    logic [LAT_W-1:0] lat;

    assign req = '{inc: inc_en, lowr: lo_wr, jump: jmp_req,
                   call: call_req, ret: ret_req, vec: irq_vec};

    pcu_srcsel u_sel (
        .req  (req),
        .src  (src),
        .push (push),
        .pop  (pop)
    );

    pcu_hilatch u_lat (
        .clk (clk),
        .rst (rst),
        .wr  (hl_wr),
        .din (hl_data),
        .q   (lat)
    );

    pcu_next #(.IMPL_W(IMPL_W)) u_nxt (
        .src       (src),
        .pc        (pc_q),
        .lat       (lat),
        .lo_data   (lo_data),
        .tgt       (jmp_tgt),
        .pop_data  (pop_data),
        .nxt       (pc_d),
        .push_data (push_data)
    );

    pcu_retstack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .pop_data  (pop_data)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_o    = pc_q;
    assign pcl_o   = pc_q[LO_W-1:0];
    assign latch_o = lat;

    // R7: vector entry lands on 0004h
    p_vec_target_r7: assert property (@(posedge clk) disable iff (rst)
        irq_vec |=> pc_o == 13'h0004);
    // R4: jump low field comes from the target
    p_jump_field_r4: assert property (@(posedge clk) disable iff (rst)
        (jmp_req && !irq_vec && !ret_req && !call_req)
        |=> pc_o[TGT_W-1:0] == $past(jmp_tgt));
    // R3: low-byte write places data in PC[7:0]
    p_lowr_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (lo_wr && !irq_vec && !ret_req && !call_req && !jmp_req)
        |=> pcl_o == $past(lo_data));
    // R6: stack operations leave the latch alone
    p_latch_keep_r6: assert property (@(posedge clk) disable iff (rst)
        ((ret_req || call_req || irq_vec) && !hl_wr) |=> $stable(latch_o));
    // R6: return loads the popped entry
    p_ret_value_r6: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !irq_vec) |=> pc_o == $past(pop_data));
    // R11: no push and pop in one cycle
    p_push_pop_r11: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: tb/pcu_top_tb.sv
module pcu_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inc_en = 0, lo_wr = 0, jmp_req = 0, call_req = 0;
    logic        ret_req = 0, irq_vec = 0, hl_wr = 0;
    logic [7:0]  lo_data = '0;
    logic [10:0] jmp_tgt = '0;
    logic [4:0]  hl_data = '0;
    logic [12:0] pc_a, pc_b;
    logic [7:0]  pcl_a, pcl_b;
    logic [4:0]  lat_a, lat_b;

    always #2 clk = ~clk;

    pcu_top u_dut (
        .clk(clk), .rst(rst), .inc_en(inc_en), .lo_wr(lo_wr), .lo_data(lo_data),
        .jmp_req(jmp_req), .call_req(call_req), .jmp_tgt(jmp_tgt),
        .ret_req(ret_req), .irq_vec(irq_vec), .hl_wr(hl_wr), .hl_data(hl_data),
        .pc_o(pc_a), .pcl_o(pcl_a), .latch_o(lat_a)
    );

    pcu_top #(.IMPL_W(12)) u_dut4k (
        .clk(clk), .rst(rst), .inc_en(inc_en), .lo_wr(lo_wr), .lo_data(lo_data),
        .jmp_req(jmp_req), .call_req(call_req), .jmp_tgt(jmp_tgt),
        .ret_req(ret_req), .irq_vec(irq_vec), .hl_wr(hl_wr), .hl_data(hl_data),
        .pc_o(pc_b), .pcl_o(pcl_b), .latch_o(lat_b)
    );

    typedef struct {
        logic [12:0] pc0;
        logic [12:0] pc1;
        logic [4:0]  lat;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;

    logic [12:0] m_pc  [2];
    logic [12:0] m_stk [2][8];
    logic [2:0]  m_sp  [2];
    logic [4:0]  m_lat;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lat = '0;
        for (int i = 0; i < 2; i++) begin
            m_pc[i] = '0;
            m_sp[i] = '0;
            for (int j = 0; j < 8; j++) m_stk[i][j] = '0;
        end
    endtask

    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            logic [12:0] mk;
            mk = (i == 0) ? 13'h1FFF : 13'h0FFF;
            if (irq_vec) begin
                m_stk[i][m_sp[i]] = m_pc[i];
                m_sp[i] = m_sp[i] + 1;
                m_pc[i] = 13'h0004;
            end else if (ret_req) begin
                m_sp[i] = m_sp[i] - 1;
                m_pc[i] = m_stk[i][m_sp[i]] & mk;
            end else if (call_req) begin
                m_stk[i][m_sp[i]] = (m_pc[i] + 13'd1) & mk;
                m_sp[i] = m_sp[i] + 1;
                m_pc[i] = {m_lat[4:3], jmp_tgt} & mk;
            end else if (jmp_req) begin
                m_pc[i] = {m_lat[4:3], jmp_tgt} & mk;
            end else if (lo_wr) begin
                m_pc[i] = {m_lat, lo_data} & mk;
            end else if (inc_en) begin
                m_pc[i] = (m_pc[i] + 13'd1) & mk;
            end
        end
        if (hl_wr) m_lat = hl_data;
    endtask

    // driver: one cycle of stimulus, expected result queued for the monitor
    task automatic drive(input string tag,
                         input logic i_inc, input logic i_lo, input logic [7:0] d,
                         input logic i_jmp, input logic i_call, input logic [10:0] t,
                         input logic i_ret, input logic i_irq,
                         input logic i_hw, input logic [4:0] hd);
        exp_t e;
        @(negedge clk);
        inc_en = i_inc; lo_wr = i_lo; lo_data = d; jmp_req = i_jmp;
        call_req = i_call; jmp_tgt = t; ret_req = i_ret; irq_vec = i_irq;
        hl_wr = i_hw; hl_data = hd;
        model_step();
        e.pc0 = m_pc[0]; e.pc1 = m_pc[1]; e.lat = m_lat; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        drive("idle", 0, 0, 8'h00, 0, 0, 11'h000, 0, 0, 0, 5'h00);
    endtask

    // monitor: compare each queued item just after the edge that produced it
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " pc"}, 32'(pc_a), 32'(e.pc0));
            check({e.tag, " R12 pcl"}, 32'(pcl_a), 32'(e.pc0[7:0]));
            check({e.tag, " R13 latch"}, 32'(lat_a), 32'(e.lat));
            check({e.tag, " R10 pc4k"}, 32'(pc_b), 32'(e.pc1));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset pc", 32'(pc_a), 0);
        check("R1 reset latch", 32'(lat_a), 0);
        check("R1 reset pc4k", 32'(pc_b), 0);

        // R2 increment
        repeat (3) drive("R2 inc", 1, 0, 8'h00, 0, 0, 11'h000, 0, 0, 0, 5'h00);
        // R13 latch write alone leaves PC put
        drive("R13 latch only", 0, 0, 8'h00, 0, 0, 11'h000, 0, 0, 1, 5'h1A);
        // R3 low-byte write uses full latch
        drive("R3 lowr", 0, 1, 8'h34, 0, 0, 11'h000, 0, 0, 0, 5'h00);
        // R2 wrap from 1FFFh, R10 wrap from 0FFFh
        drive("R13 latch 1F", 0, 0, 8'h00, 0, 0, 11'h000, 0, 0, 1, 5'h1F);
        drive("R3 lowr FF", 0, 1, 8'hFF, 0, 0, 11'h000, 0, 0, 0, 5'h00);
        drive("R2 wrap", 1, 0, 8'h00, 0, 0, 11'h000, 0, 0, 0, 5'h00);
        // R4 jump uses latch[4:3]
        drive("R13 latch 1A", 0, 0, 8'h00, 0, 0, 11'h000, 0, 0, 1, 5'h1A);
        drive("R4 jump", 0, 0, 8'h00, 1, 0, 11'h123, 0, 0, 0, 5'h00);
        // R5 call then R6 return
        drive("R13 latch 08", 0, 0, 8'h00, 0, 0, 11'h000, 0, 0, 1, 5'h08);
        drive("R5 call", 0, 0, 8'h00, 0, 1, 11'h456, 0, 0, 0, 5'h00);
        drive("R5 inc in sub", 1, 0, 8'h00, 0, 0, 11'h000, 0, 0, 0, 5'h00);
        drive("R6 return", 0, 0, 8'h00, 0, 0, 11'h000, 1, 0, 0, 5'h00);
        // R7 vector pushes unincremented PC
        drive("R7 vector", 0, 0, 8'h00, 0, 0, 11'h000, 0, 1, 0, 5'h00);
        drive("R7 return", 0, 0, 8'h00, 0, 0, 11'h000, 1, 0, 0, 5'h00);
        // R11 priority
        drive("R11 all", 1, 1, 8'h77, 1, 1, 11'h7FF, 1, 1, 0, 5'h00);
        drive("R11 ret over call", 1, 1, 8'h77, 1, 1, 11'h7FF, 1, 0, 0, 5'h00);
        drive("R11 call over jump", 1, 1, 8'h77, 1, 1, 11'h2AA, 0, 0, 0, 5'h00);
        drive("R11 jump over lowr", 1, 1, 8'h77, 1, 0, 11'h155, 0, 0, 0, 5'h00);
        drive("R11 lowr over inc", 1, 1, 8'h99, 0, 0, 11'h000, 0, 0, 0, 5'h00);
        // R13 same-cycle latch write uses old value
        drive("R13 lowr old latch", 0, 1, 8'h42, 0, 0, 11'h000, 0, 0, 1, 5'h13);
        drive("R13 new latch", 0, 1, 8'h43, 0, 0, 11'h000, 0, 0, 0, 5'h00);
        // R6 latch unchanged across push and pop
        drive("R6 call keep latch", 0, 0, 8'h00, 0, 1, 11'h3C3, 0, 0, 0, 5'h00);
        drive("R6 ret keep latch", 0, 0, 8'h00, 0, 0, 11'h000, 1, 0, 0, 5'h00);
        // R8 nine calls from distinct pages; R9 ten returns past empty
        for (int k = 0; k < 9; k++) begin
            drive("R8 call", 0, 0, 8'h00, 0, 1, 11'(k * 11'h0F1 + 11'h011), 0, 0, 1, 5'(k * 3));
        end
        for (int k = 0; k < 10; k++) begin
            drive((k < 9) ? "R8 pop" : "R9 pop empty", 0, 0, 8'h00, 0, 0, 11'h000, 1, 0, 0, 5'h00);
        end
        // R10 jump above 0FFFh on the 4K instance
        drive("R10 latch 18", 0, 0, 8'h00, 0, 0, 11'h000, 0, 0, 1, 5'h18);
        drive("R10 jump high", 0, 0, 8'h00, 1, 0, 11'h7F0, 0, 0, 0, 5'h00);
        repeat (2) idle();
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule